// File: doc/BRIEF.md
# Selectable-Order Burst Address Sequencer

This block produces the address stream for a four-beat memory burst. A start address is captured from the external address bus on a load strobe. From then on, the upper address bits stay frozen and a two-bit beat counter produces the two low bits. The block needs no further external addresses until the next load.

A mode input picks the beat order. In interleaved order, the captured low bits are XORed with the beat number. In linear order, the beat number is added to the captured low bits modulo four. An active-low advance input steps to the next beat on a rising clock edge. When advance is inactive, the beat is held, which inserts a wait cycle without skipping a beat. The mode input acts combinationally on the held state, so it is normally kept steady for the whole of a burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the beat counter and the captured start address both clear, so `addr_out` reads all zeros in the following cycle.
- R2: When `load` is high at a rising edge, the whole of `addr_in` is captured and `addr_out` equals it exactly from that edge on, in either order mode (first beat offset 0).
- R3: With `order_il` high (interleaved order), beat k, where k counts advances since the load modulo 4, has low bits equal to start_low XOR k. A start of 01 gives 01, 00, 11, 10, and a start of 10 gives 10, 11, 00, 01.
- R4: With `order_il` low (linear order), beat k has low bits equal to (start_low + k) mod 4. A start of 01 gives 01, 10, 11, 00, and a start of 11 gives 11, 00, 01, 10.
- R5: With `load` low and `adv_n` low at a rising edge, the beat moves forward by exactly one.
- R6: With `load` low and `adv_n` high at a rising edge, the beat and `addr_out` are held unchanged (a wait cycle). The following advance resumes at the next beat, with no beat skipped.
- R7: When `load` is high and `adv_n` is low at the same edge, the load wins: the output shows the new start address at beat 0.
- R8: Bits above the two low bits of `addr_out` never change except on a load. Advancing beyond the fourth beat wraps the beat number modulo 4 and keeps the same order and start offset.
- R9: `order_il` acts combinationally on `addr_out` without changing any stored state. Switching it mid-burst immediately shows the other order's address for the same beat number.
- R10: `addr_in` has no effect on `addr_out` in any cycle in which `load` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | High: capture `addr_in` as the burst start address |
| adv_n | input | 1 | Low: step to the next beat; high: hold the current beat |
| order_il | input | 1 | 1 = interleaved (XOR) order, 0 = linear modulo-4 order |
| addr_in | input | AW | External start address |
| addr_out | output | AW | Current burst address |

## Verification
Load and advance are the two functions that can be requested at the same edge. The bench drives `load` high with `adv_n` low mid-burst, and expects the new start address at beat 0 rather than an advanced beat. It also changes `addr_in` while only advancing or holding, and expects the output to ignore it. A behavioural model built on integer beat counts and start offsets predicts every cycle in both order modes, including the wrap past the fourth beat.

// File: rtl/bseq_pkg.sv
// Package: shared constants and the beat-order mixing function for the
// burst address sequencer. Assumes a power-of-two burst length.
package bseq_pkg;

    localparam int BURST_LEN = 4;
    localparam int BEAT_W    = $clog2(BURST_LEN);

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    // Map a start offset and beat number to the low address bits.
    function automatic beat_t mix_beat(input beat_t start_lo, input beat_t beat, input order_e ord);
        beat_t res;
        if (ord == ORD_INTERLEAVE) begin
            res = start_lo ^ beat;
        end else begin
            res = start_lo + beat;
        end
        return res;
    endfunction

endpackage

// File: rtl/bseq_beat_ctr.sv
// Module: bseq_beat_ctr
// Beat counter for one burst. It clears on reset or load, and steps by one
// when the active-low advance input is low. Load has priority over advance.
// Assumes the counter width is given by the package beat type (wraps
// naturally modulo the burst length).
module bseq_beat_ctr
    import bseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  logic  adv_n,
    output beat_t beat
);

    beat_t beat_q;

    // Purpose: clear on reset/load, step on advance, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (load) begin
            beat_q <= '0;
        end else if (!adv_n) begin
            beat_q <= beat_q + beat_t'(1);
        end
    end

    assign beat = beat_q;

endmodule

// File: rtl/bseq_base_reg.sv
// Module: bseq_base_reg
// Holds the burst start address captured from the external bus on load.
// Assumes the address is at least BEAT_W + 1 bits wide. Nothing but reset
// and load alters the stored value.
module bseq_base_reg #(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] base
);

    logic [AW-1:0] base_q;

    // Purpose: capture the external start address on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (load) begin
            base_q <= addr_in;
        end
    end

    assign base = base_q;

endmodule

// File: rtl/bseq_order_mix.sv
// Module: bseq_order_mix
// Combinational address former. The upper bits pass straight from the stored
// base. The low bits come from the base low bits and the beat number in the
// selected order. Assumes AW > BEAT_W.
module bseq_order_mix
    import bseq_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic [AW-1:0] base,
    input  beat_t         beat,
    input  logic          order_il,
    output logic [AW-1:0] addr
);

    localparam int HI_W = AW - BEAT_W;

    beat_t  low_bits;
    order_e ord;

    assign ord = order_e'(order_il);

    // Purpose: select the low address bits for this beat in the chosen order.
    always_comb begin
        low_bits = mix_beat(base[BEAT_W-1:0], beat, ord);
    end

    // Purpose: join the frozen upper bits with the generated low bits.
    always_comb begin
        addr = {base[AW-1 -: HI_W], low_bits};
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Four-beat burst address sequencer. The start address is captured on load,
// the two low bits are generated internally, and the order (interleaved or
// linear) is selected by order_il. Synchronous active-low reset. Assumes
// order_il is held steady within a burst when a consistent order is wanted.
module burst_addr_seq #(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv_n,
    input  logic          order_il,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out
);

    import bseq_pkg::*;

    logic [AW-1:0] base;
    beat_t         beat;

    bseq_base_reg #(.AW(AW)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .addr_in (addr_in),
        .base    (base)
    );

    bseq_beat_ctr u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .adv_n (adv_n),
        .beat  (beat)
    );

    bseq_order_mix #(.AW(AW)) u_mix (
        .base     (base),
        .beat     (beat),
        .order_il (order_il),
        .addr     (addr_out)
    );

endmodule

// File: rtl/bseq_checker.sv
// Module: bseq_checker
// Temporal checks on the sequencer ports, attached to every instance of the
// top module through the bind below.
module bseq_checker #(
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load,
    input logic          adv_n,
    input logic          order_il,
    input logic [AW-1:0] addr_in,
    input logic [AW-1:0] addr_out
);

    // R1: reset clears the output in the next cycle.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> addr_out == '0);

    // R2 / R7: a load shows the captured address exactly, whatever adv_n is.
    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr_out == $past(addr_in));

    // R5: an advance changes the low bits when the order stays put.
    assert_advance_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv_n) |=> ($stable(order_il) -> addr_out[1:0] != $past(addr_out[1:0])));

    // R4: in linear order an advance adds one to the low bits modulo 4.
    assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv_n && !order_il) |=> ($stable(order_il) -> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1));

    // R6: a wait cycle holds the output when the order stays put.
    assert_wait_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv_n) |=> ($stable(order_il) -> $stable(addr_out)));

    // R8: upper bits change only on a load.
    assert_upper_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_out[AW-1:2]));

endmodule

bind burst_addr_seq bseq_checker #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .adv_n    (adv_n),
    .order_il (order_il),
    .addr_in  (addr_in),
    .addr_out (addr_out)
);

// File: tb/sim_burst_addr_seq.sv
// Bench for burst_addr_seq. A behavioural model built on integers predicts
// the address in every cycle and compares it at the falling edge.
module sim_burst_addr_seq;

    localparam int AW     = 18;
    localparam int CLK_NS = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic          adv_n = 1'b1;
    logic          order_il = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int n_checks = 0;
    int n_fails  = 0;
    int ref_base = 0;
    int ref_k    = 0;

    always #(CLK_NS/2) clk = ~clk;

    burst_addr_seq #(.AW(AW)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv_n    (adv_n),
        .order_il (order_il),
        .addr_in  (addr_in),
        .addr_out (addr_out)
    );

    function automatic int model_addr(input logic il);
        int lo = ref_base % 4;
        int hi = ref_base - lo;
        if (il) return hi + (lo ^ (ref_k % 4));
        return hi + ((lo + ref_k) % 4);
    endfunction

    task automatic check(input string tag);
        int exp_v = model_addr(order_il);
        n_checks++;
        if (int'(addr_out) != exp_v) begin
            n_fails++;
            $display("FAIL %s: addr_out=%05h expected=%05h", tag, addr_out, exp_v);
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising edge,
    // and compare at the next falling edge.
    task automatic cyc(input logic ld, input logic adv, input logic il,
                       input int a, input string tag);
        load = ld; adv_n = adv; order_il = il; addr_in = AW'(a);
        @(posedge clk);
        if (!rst_n) begin
            ref_base = 0; ref_k = 0;
        end else if (ld) begin
            ref_base = a; ref_k = 0;
        end else if (!adv) begin
            ref_k++;
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset clears state
        cyc(1'b0, 1'b0, 1'b1, 'h3FFFF, "R1 reset");
        cyc(1'b1, 1'b0, 1'b1, 'h12345, "R1 reset with load");
        rst_n = 1'b1;

        // R2, R3: interleaved, start low 01
        cyc(1'b1, 1'b1, 1'b1, 'h2A5C1, "R2 load interleaved");
        cyc(1'b0, 1'b0, 1'b1, 'h00000, "R3 beat1 R10");
        cyc(1'b0, 1'b0, 1'b1, 'h3FFFF, "R3 beat2 R10");
        // R6: wait cycles do not skip
        cyc(1'b0, 1'b1, 1'b1, 'h11111, "R6 hold");
        cyc(1'b0, 1'b1, 1'b1, 'h22222, "R6 hold2");
        cyc(1'b0, 1'b0, 1'b1, 'h33333, "R3 beat3 R5");
        // R8: wrap past fourth beat
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 1'b1, i * 'h1111, "R8 wrap");

        // R3: interleaved, start low 10
        cyc(1'b1, 1'b1, 1'b1, 'h0FFFE, "R2 load 10");
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b1, 'h3FFFF, "R3 start10");

        // R4: linear, start low 11 and 01
        cyc(1'b1, 1'b0, 1'b0, 'h1ABCF, "R7 load over adv linear");
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b0, 'h00000, "R4 linear start11");
        cyc(1'b1, 1'b1, 1'b0, 'h35551, "R2 load linear 01");
        cyc(1'b0, 1'b1, 1'b0, 'h00002, "R6 hold linear R10");
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0, 'h2AAAA, "R4 linear start01");

        // R9: switch order mid-burst without a clock edge
        cyc(1'b1, 1'b1, 1'b1, 'h00005, "R2 load for R9");
        cyc(1'b0, 1'b0, 1'b1, 'h00000, "R3 beat1 before R9");
        order_il = 1'b0; #1; check("R9 switch to linear");
        order_il = 1'b1; #1; check("R9 switch back");

        // R7: load wins mid-burst
        cyc(1'b0, 1'b0, 1'b1, 'h00000, "R5 advance");
        cyc(1'b1, 1'b0, 1'b1, 'h3C00A, "R7 load over adv");
        cyc(1'b0, 1'b0, 1'b1, 'h00000, "R7 next beat after load");

        // R1: reset mid-burst
        rst_n = 1'b0;
        cyc(1'b0, 1'b0, 1'b1, 'h12345, "R1 mid reset");
        rst_n = 1'b1;
        cyc(1'b0, 1'b1, 1'b1, 'h3FFFF, "R1 R10 after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule